// File: doc/BRIEF.md
# Seconds counter with alarm

A free-running time base for a low-power domain. Each low-power tick (one per cycle of a 32.768 kHz clock, presented to the block as a one-cycle strobe) advances a 47-bit count. The count is seen by software as two words: a 32-bit whole-seconds word and a 15-bit sub-second fraction. A 32-bit alarm word is compared with the seconds count each time the seconds value steps. A match sets a sticky alarm flag, and that flag drives an interrupt line when the alarm interrupt is enabled.

The count runs only when the block is healthy. It stops when its enable bit is clear, when the overflow flag is up, or when the not-valid flag is up. The not-valid flag is up after every reset. Coming back from a stop is a deliberate software sequence: clear the flags, set the enable, then load a seconds value. Two lock bits let software freeze the time words against later writes. One lock can be released by software. The other stays set until reset.

Software reaches the block through a one-cycle write strobe with an address and data, and through a combinational read port.

Top module: `rtc_seconds_alarm`

## Requirements
- R1: While running, each tick adds one to the fraction. The fraction reads at address 1 in bits 14:0. When a tick finds the fraction at 0x7FFF, the fraction becomes 0 and the seconds word (address 0) goes up by one. A register write takes effect at the clock edge that samples it, and reads return the addressed register in the same cycle.
- R2: After reset the status register (address 4) reads 0x4, with the not-valid flag in bit 2 set. Control (address 3), seconds, fraction and interrupt enable (address 5) all read 0, the alarm word (address 2) reads 0xFFFFFFFF, and the interrupt output is low.
- R3: No tick changes the seconds or the fraction while control bit 0 (enable) is 0, while status bit 1 (overflow) is 1, or while status bit 2 (not-valid) is 1.
- R4: Once counting has stopped because of reset or overflow, it resumes only when all of the following hold: not-valid and overflow are both clear, enable is 1, and an accepted write to the seconds word has happened since the stop. Clearing the enable bit and setting it again needs no new seconds write.
- R5: A tick with seconds at 0xFFFFFFFF and fraction at 0x7FFF sets both words to 0 and sets the overflow flag, status bit 1.
- R6: When a tick steps the seconds word to a value equal to the alarm word, the alarm flag (status bit 0) is set. It stays set until it is cleared.
- R7: An alarm word of 0xFFFFFFFF never sets the alarm flag.
- R8: The alarm is evaluated only on a seconds step. Further ticks within the matching second do not set the flag again, and writing the seconds word to the alarm value does not set it.
- R9: The interrupt output is high exactly while the alarm flag and interrupt-enable bit 0 (address 5) are both 1.
- R10: Writing 1 to a status bit clears that bit, and writing 0 to it has no effect. An event that sets a flag in the same cycle as a clear of that flag wins, so the flag ends up set.
- R11: Control bit 1 is a soft lock, which writes can set and clear. Control bit 2 is a hard lock: once written to 1 it stays 1 until reset. While either lock is 1, writes to the seconds and fraction words are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe per low-power clock period |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address: 0 seconds, 1 fraction, 2 alarm, 3 control, 4 status, 5 interrupt enable |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 3 | Read address, same map as writes |
| rd_data_o | output | 32 | Read data for rd_addr_i, unused bits zero |
| alarm_irq_o | output | 1 | Alarm interrupt |

## Verification
Every register change is due at the one clock edge that samples the write or the tick. The read port is combinational, so the new value appears in the cycle just after that edge. The alarm flag, the overflow flag and the interrupt line change at the same edge as the tick that steps the seconds word, with no extra cycle of delay. The bench drives inputs just after a rising edge and samples outputs on the falling edge. A behavioural model steps at each rising edge and is compared with the read data and the interrupt line on every falling edge. Directed checks read registers only once the tick strobe is idle, so each expected value follows from a known number of ticks.

// File: rtl/rs_pkg.sv
// Shared definitions for the seconds counter with alarm: register
// addresses, control bit positions and the status flag layout.
package rs_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_SEC   = 3'd0,
        RA_FRAC  = 3'd1,
        RA_ALARM = 3'd2,
        RA_CTRL  = 3'd3,
        RA_STAT  = 3'd4,
        RA_IRQEN = 3'd5
    } reg_addr_e;

    localparam int CB_EN   = 0;
    localparam int CB_SOFT = 1;
    localparam int CB_HARD = 2;

    localparam int STAT_W = 3;

    // Status word layout: bit 2 not-valid, bit 1 overflow, bit 0 alarm.
    typedef struct packed {
        logic nv;
        logic ovf;
        logic alm;
    } stat_t;

    localparam stat_t STAT_RST = '{nv: 1'b1, ovf: 1'b0, alm: 1'b0};
endpackage

// File: rtl/rs_time_base.sv
// Seconds and fraction registers.
// Assumes the caller never asserts step_i in a cycle with a load, and that
// FRAC_W < SEC_W so load data carries a whole fraction.
module rs_time_base #(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              sec_ld_i,
    input  logic              frac_ld_i,
    input  logic [SEC_W-1:0]  ld_data_i,
    output logic [SEC_W-1:0]  sec_o,
    output logic [FRAC_W-1:0] frac_o,
    output logic              roll_o,
    output logic              wrap_o,
    output logic [SEC_W-1:0]  sec_next_o
);
    localparam logic [FRAC_W-1:0] FRAC_MAX = '1;
    localparam logic [SEC_W-1:0]  SEC_MAX  = '1;

    logic [SEC_W-1:0]  sec_q;
    logic [FRAC_W-1:0] frac_q;

    // Step events derived from the current count.
    assign roll_o     = step_i && (frac_q == FRAC_MAX);
    assign wrap_o     = roll_o && (sec_q == SEC_MAX);
    assign sec_next_o = sec_q + SEC_W'(1);

    // Seconds word: load has priority over a rollover step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= '0;
        end else if (sec_ld_i) begin
            sec_q <= ld_data_i;
        end else if (roll_o) begin
            sec_q <= sec_next_o;
        end
    end

    // Fraction word: load, else advance and wrap naturally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frac_q <= '0;
        end else if (frac_ld_i) begin
            frac_q <= ld_data_i[FRAC_W-1:0];
        end else if (step_i) begin
            frac_q <= frac_q + FRAC_W'(1);
        end
    end

    assign sec_o  = sec_q;
    assign frac_o = frac_q;
endmodule

// File: rtl/rs_alarm_unit.sv
// Alarm seconds register and compare.
// Assumes roll_i marks a seconds step and sec_next_i is the value it steps to.
// The all-ones value is treated as unset.
module rs_alarm_unit #(
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_i,
    input  logic [SEC_W-1:0] ld_data_i,
    input  logic             roll_i,
    input  logic [SEC_W-1:0] sec_next_i,
    output logic [SEC_W-1:0] alarm_o,
    output logic             match_o
);
    localparam logic [SEC_W-1:0] UNSET = '1;

    logic [SEC_W-1:0] alarm_q;

    // Alarm word storage, unset after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q <= UNSET;
        end else if (ld_i) begin
            alarm_q <= ld_data_i;
        end
    end

    // Compare is evaluated only on a seconds step.
    assign match_o = roll_i && (sec_next_i == alarm_q) && (alarm_q != UNSET);
    assign alarm_o = alarm_q;
endmodule

// File: rtl/rs_ctl_stat.sv
// Control, status and interrupt-enable state, plus the run qualifier.
// Assumes the write strobes are already decoded. Status flags are
// write-1-to-clear, and a set event in the same cycle wins over a clear.
module rs_ctl_stat
    import rs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr_i,
    input  logic              stat_wr_i,
    input  logic              ien_wr_i,
    input  logic [STAT_W-1:0] wr_bits_i,
    input  logic              sec_ld_i,
    input  logic              match_i,
    input  logic              wrap_i,
    output logic              cnt_en_o,
    output logic              soft_lk_o,
    output logic              hard_lk_o,
    output stat_t             stat_o,
    output logic              irq_en_o,
    output logic              run_o
);
    logic  en_q, soft_q, hard_q, ien_q, primed_q;
    stat_t stat_q, stat_set, stat_clr;

    // Control bits: enable and soft lock follow writes, hard lock only sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            soft_q <= 1'b0;
            hard_q <= 1'b0;
        end else if (ctrl_wr_i) begin
            en_q   <= wr_bits_i[CB_EN];
            soft_q <= wr_bits_i[CB_SOFT];
            hard_q <= hard_q | wr_bits_i[CB_HARD];
        end
    end

    // Interrupt enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q <= 1'b0;
        end else if (ien_wr_i) begin
            ien_q <= wr_bits_i[0];
        end
    end

    // Primed: a seconds load has happened since the last reset or overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            primed_q <= 1'b0;
        end else if (wrap_i) begin
            primed_q <= 1'b0;
        end else if (sec_ld_i) begin
            primed_q <= 1'b1;
        end
    end

    // Set and clear vectors for the status flags.
    always_comb begin
        stat_set     = '0;
        stat_set.alm = match_i;
        stat_set.ovf = wrap_i;
        stat_clr     = stat_wr_i ? stat_t'(wr_bits_i) : stat_t'('0);
    end

    // One register per status flag, each with its own reset value.
    for (genvar i = 0; i < STAT_W; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stat_q[i] <= STAT_RST[i];
            end else begin
                stat_q[i] <= (stat_q[i] & ~stat_clr[i]) | stat_set[i];
            end
        end
    end

    assign run_o     = en_q && !stat_q.ovf && !stat_q.nv && primed_q;
    assign cnt_en_o  = en_q;
    assign soft_lk_o = soft_q;
    assign hard_lk_o = hard_q;
    assign stat_o    = stat_q;
    assign irq_en_o  = ien_q;
endmodule

// File: rtl/rtc_seconds_alarm.sv
// Seconds counter with alarm: top level.
// Decodes register writes, gates ticks by the run qualifier and the locks,
// and muxes the read port. Assumes tick_i is a one-cycle strobe per
// low-power clock period, already in this clock domain.
module rtc_seconds_alarm
    import rs_pkg::*;
#(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [SEC_W-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [SEC_W-1:0]  rd_data_o,
    output logic              alarm_irq_o
);
    logic [SEC_W-1:0]  sec_val, sec_next, alarm_val;
    logic [FRAC_W-1:0] frac_val;
    logic wr_sec, wr_frac, wr_alarm, wr_ctrl, wr_stat, wr_ien;
    logic sec_ld, frac_ld, lock_any, step, roll, wrap, match;
    logic cnt_en, soft_lk, hard_lk, irq_en, run;
    stat_t stat;

    // Write address decode.
    always_comb begin
        wr_sec   = wr_en_i && (wr_addr_i == RA_SEC);
        wr_frac  = wr_en_i && (wr_addr_i == RA_FRAC);
        wr_alarm = wr_en_i && (wr_addr_i == RA_ALARM);
        wr_ctrl  = wr_en_i && (wr_addr_i == RA_CTRL);
        wr_stat  = wr_en_i && (wr_addr_i == RA_STAT);
        wr_ien   = wr_en_i && (wr_addr_i == RA_IRQEN);
    end

    // Lock gating of time writes, and tick qualification.
    assign lock_any = soft_lk || hard_lk;
    assign sec_ld   = wr_sec && !lock_any;
    assign frac_ld  = wr_frac && !lock_any;
    assign step     = tick_i && run && !sec_ld && !frac_ld;

    rs_time_base #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_time (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (step),
        .sec_ld_i   (sec_ld),
        .frac_ld_i  (frac_ld),
        .ld_data_i  (wr_data_i),
        .sec_o      (sec_val),
        .frac_o     (frac_val),
        .roll_o     (roll),
        .wrap_o     (wrap),
        .sec_next_o (sec_next)
    );

    rs_alarm_unit #(.SEC_W(SEC_W)) u_alarm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_i       (wr_alarm),
        .ld_data_i  (wr_data_i),
        .roll_i     (roll),
        .sec_next_i (sec_next),
        .alarm_o    (alarm_val),
        .match_o    (match)
    );

    rs_ctl_stat u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr_i (wr_ctrl),
        .stat_wr_i (wr_stat),
        .ien_wr_i  (wr_ien),
        .wr_bits_i (wr_data_i[STAT_W-1:0]),
        .sec_ld_i  (sec_ld),
        .match_i   (match),
        .wrap_i    (wrap),
        .cnt_en_o  (cnt_en),
        .soft_lk_o (soft_lk),
        .hard_lk_o (hard_lk),
        .stat_o    (stat),
        .irq_en_o  (irq_en),
        .run_o     (run)
    );

    // Combinational read mux, unused bits zero.
    always_comb begin
        case (rd_addr_i)
            RA_SEC:   rd_data_o = sec_val;
            RA_FRAC:  rd_data_o = {{(SEC_W-FRAC_W){1'b0}}, frac_val};
            RA_ALARM: rd_data_o = alarm_val;
            RA_CTRL:  rd_data_o = {{(SEC_W-3){1'b0}}, hard_lk, soft_lk, cnt_en};
            RA_STAT:  rd_data_o = {{(SEC_W-STAT_W){1'b0}}, stat};
            RA_IRQEN: rd_data_o = {{(SEC_W-1){1'b0}}, irq_en};
            default:  rd_data_o = '0;
        endcase
    end

    // Alarm interrupt: flag qualified by its enable.
    assign alarm_irq_o = stat.alm && irq_en;
endmodule

// File: rtl/rs_seconds_alarm_chk.sv
// Property checker for rtc_seconds_alarm, attached with bind below.
// It observes the ports and the state between the submodules.
module rs_seconds_alarm_chk #(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic              wr_en_i,
    input logic [2:0]        wr_addr_i,
    input logic              wr_d0,
    input logic [SEC_W-1:0]  sec_val,
    input logic [FRAC_W-1:0] frac_val,
    input logic [SEC_W-1:0]  alarm_val,
    input logic              cnt_en,
    input logic              soft_lk,
    input logic              hard_lk,
    input logic              ovf_flag,
    input logic              nv_flag,
    input logic              alm_flag,
    input logic              run
);
    localparam logic [FRAC_W-1:0] FRAC_MAX = '1;
    localparam logic [SEC_W-1:0]  SEC_MAX  = '1;

    logic time_wr;
    assign time_wr = wr_en_i && (wr_addr_i == 3'd0 || wr_addr_i == 3'd1);

    // R3: a halted counter keeps both time words unless they are written.
    a_r3_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((!cnt_en || ovf_flag || nv_flag) && !time_wr)
        |=> ($stable(sec_val) && $stable(frac_val)));

    // R5: a tick at the top of the count wraps to zero and raises overflow.
    a_r5_wrap_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && run && !time_wr && sec_val == SEC_MAX && frac_val == FRAC_MAX)
        |=> (ovf_flag && sec_val == '0 && frac_val == '0));

    // R7: an unset alarm never raises the flag.
    a_r7_unset_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_val == SEC_MAX && !alm_flag) |=> !alm_flag);

    // R8: the flag only rises after a tick that rolled the fraction.
    a_r8_rise_on_roll: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alm_flag) |-> ($past(tick_i) && $past(frac_val) == FRAC_MAX));

    // R10: writing 0 to the alarm bit keeps a set flag.
    a_r10_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == 3'd4 && !wr_d0 && alm_flag) |=> alm_flag);

    // R11: locked seconds writes without a tick leave the seconds word alone.
    a_r11_locked_sec: assert property (@(posedge clk) disable iff (!rst_n)
        ((soft_lk || hard_lk) && wr_en_i && wr_addr_i == 3'd0 && !tick_i)
        |=> $stable(sec_val));

    // R11: the hard lock stays set until reset.
    a_r11_hard_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        hard_lk |=> hard_lk);
endmodule

bind rtc_seconds_alarm rs_seconds_alarm_chk #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_d0     (wr_data_i[0]),
    .sec_val   (sec_val),
    .frac_val  (frac_val),
    .alarm_val (alarm_val),
    .cnt_en    (cnt_en),
    .soft_lk   (soft_lk),
    .hard_lk   (hard_lk),
    .ovf_flag  (stat.ovf),
    .nv_flag   (stat.nv),
    .alm_flag  (stat.alm),
    .run       (run)
);

// File: tb/rtc_seconds_alarm_tb.sv
`timescale 1ns/1ps
module rtc_seconds_alarm_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = 3'd0;
    logic [31:0] wr_data = 32'd0;
    logic [2:0]  rd_addr = 3'd0;
    logic [31:0] rd_data;
    logic        irq;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit started = 1'b0;
    bit done = 1'b0;

    rtc_seconds_alarm u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data), .alarm_irq_o(irq)
    );

    always #2.5 clk = ~clk;

    // Behavioural reference state.
    bit [31:0] m_sec, m_alarm;
    bit [14:0] m_frac;
    bit m_en, m_soft, m_hard, m_alm, m_ovf, m_nv, m_prim, m_ien;

    // Model step at every rising edge.
    always @(posedge clk) begin
        bit set_alm, set_ovf, lk, running, swr, fwr;
        started = 1'b1;
        if (!rst_n) begin
            m_sec = 0; m_frac = 0; m_alarm = 32'hFFFF_FFFF;
            m_en = 0; m_soft = 0; m_hard = 0; m_alm = 0; m_ovf = 0;
            m_nv = 1; m_prim = 0; m_ien = 0;
        end else begin
            set_alm = 0; set_ovf = 0;
            lk = m_soft || m_hard;
            running = m_en && !m_ovf && !m_nv && m_prim;
            swr = wr_en && wr_addr == 3'd0 && !lk;
            fwr = wr_en && wr_addr == 3'd1 && !lk;
            if (swr) begin
                m_sec = wr_data; m_prim = 1;
            end else if (fwr) begin
                m_frac = wr_data[14:0];
            end else if (running && tick) begin
                if (m_frac == 15'h7FFF) begin
                    m_frac = 0;
                    if (m_sec == 32'hFFFF_FFFF) begin
                        m_sec = 0; set_ovf = 1; m_prim = 0;
                    end else begin
                        m_sec = m_sec + 1;
                    end
                    if (m_sec == m_alarm && m_alarm != 32'hFFFF_FFFF) set_alm = 1;
                end else begin
                    m_frac = m_frac + 1;
                end
            end
            if (wr_en && wr_addr == 3'd2) m_alarm = wr_data;
            if (wr_en && wr_addr == 3'd3) begin
                m_en = wr_data[0]; m_soft = wr_data[1]; m_hard = m_hard | wr_data[2];
            end
            if (wr_en && wr_addr == 3'd4) begin
                if (wr_data[0]) m_alm = 0;
                if (wr_data[1]) m_ovf = 0;
                if (wr_data[2]) m_nv = 0;
            end
            if (wr_en && wr_addr == 3'd5) m_ien = wr_data[0];
            m_alm = m_alm | set_alm;
            m_ovf = m_ovf | set_ovf;
        end
    end

    function automatic logic [31:0] model_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_sec;
            3'd1: return {17'd0, m_frac};
            3'd2: return m_alarm;
            3'd3: return {29'd0, m_hard, m_soft, m_en};
            3'd4: return {29'd0, m_nv, m_ovf, m_alm};
            3'd5: return {31'd0, m_ien};
            default: return 32'd0;
        endcase
    endfunction

    // Per-cycle comparison against the model, on the falling edge.
    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if (rd_data !== model_rd(rd_addr) || irq !== (m_alm && m_ien)) begin
                errors++;
                $display("FAIL model R1 addr=%0d actual=%h/%b expected=%h/%b",
                         rd_addr, rd_data, irq, model_rd(rd_addr), m_alm && m_ien);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog R1 actual=%0d expected<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        @(posedge clk); #1;
        tick = 1'b1;
        repeat (n) @(posedge clk);
        #1 tick = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_reg(input string tag, input logic [2:0] a, input logic [31:0] exp);
        @(posedge clk); #1;
        rd_addr = a;
        @(negedge clk);
        chk(tag, rd_data, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        chk_reg("R2 status", 3'd4, 32'h4);
        chk_reg("R2 control", 3'd3, 32'h0);
        chk_reg("R2 alarm", 3'd2, 32'hFFFF_FFFF);
        chk_reg("R2 seconds", 3'd0, 32'h0);
        chk_reg("R2 fraction", 3'd1, 32'h0);
        chk_reg("R2 irq enable", 3'd5, 32'h0);
        chk("R2 irq", {31'd0, irq}, 32'h0);

        run(10);
        chk_reg("R3 not-valid halt", 3'd1, 32'h0);

        wr(3'd4, 32'h4);
        wr(3'd3, 32'h1);
        run(5);
        chk_reg("R4 no seconds load", 3'd1, 32'h0);
        wr(3'd1, 32'h0);
        wr(3'd0, 32'd10);
        run(5);
        chk_reg("R4 resumed", 3'd1, 32'd5);
        run(32763);
        chk_reg("R1 fraction wrapped", 3'd1, 32'd0);
        chk_reg("R1 seconds stepped", 3'd0, 32'd11);

        wr(3'd2, 32'd12);
        wr(3'd1, 32'h7FFC);
        run(3);
        chk_reg("R6 before step", 3'd4, 32'h0);
        run(1);
        chk_reg("R6 alarm set", 3'd4, 32'h1);
        chk_reg("R1 seconds 12", 3'd0, 32'd12);
        chk("R9 irq disabled", {31'd0, irq}, 32'h0);
        wr(3'd5, 32'h1);
        @(negedge clk);
        chk("R9 irq enabled", {31'd0, irq}, 32'h1);
        wr(3'd4, 32'h0);
        chk_reg("R10 zero write", 3'd4, 32'h1);
        wr(3'd4, 32'h1);
        chk_reg("R10 cleared", 3'd4, 32'h0);
        chk("R9 irq after clear", {31'd0, irq}, 32'h0);
        run(100);
        chk_reg("R8 same second", 3'd4, 32'h0);
        wr(3'd0, 32'd12);
        chk_reg("R8 seconds write", 3'd4, 32'h0);

        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd1, 32'h7FFF);
        wr(3'd0, 32'hFFFF_FFFE);
        run(1);
        chk_reg("R7 seconds max", 3'd0, 32'hFFFF_FFFF);
        chk_reg("R7 unset alarm", 3'd4, 32'h0);

        wr(3'd1, 32'h7FFF);
        run(1);
        chk_reg("R5 seconds wrap", 3'd0, 32'h0);
        chk_reg("R5 overflow", 3'd4, 32'h2);
        run(10);
        chk_reg("R3 overflow halt", 3'd1, 32'h0);
        wr(3'd4, 32'h2);
        chk_reg("R10 ovf cleared", 3'd4, 32'h0);
        run(10);
        chk_reg("R4 needs seconds", 3'd1, 32'h0);
        wr(3'd0, 32'd5);
        run(3);
        chk_reg("R4 restart", 3'd1, 32'd3);

        wr(3'd3, 32'h0);
        run(10);
        chk_reg("R3 enable off", 3'd1, 32'd3);
        wr(3'd3, 32'h1);
        run(2);
        chk_reg("R4 re-enable", 3'd1, 32'd5);

        wr(3'd2, 32'd6);
        wr(3'd1, 32'h7FFF);
        @(posedge clk); #1;
        tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd4; wr_data = 32'h1;
        @(posedge clk); #1;
        tick = 1'b0; wr_en = 1'b0;
        chk_reg("R10 set wins", 3'd4, 32'h1);
        chk_reg("R6 seconds 6", 3'd0, 32'd6);
        wr(3'd4, 32'h1);

        wr(3'd3, 32'h3);
        wr(3'd0, 32'd99);
        chk_reg("R11 soft lock sec", 3'd0, 32'd6);
        wr(3'd1, 32'h123);
        chk_reg("R11 soft lock frac", 3'd1, 32'd0);
        wr(3'd3, 32'h1);
        wr(3'd0, 32'd7);
        chk_reg("R11 unlocked", 3'd0, 32'd7);
        wr(3'd3, 32'h5);
        wr(3'd3, 32'h1);
        chk_reg("R11 hard sticky", 3'd3, 32'h5);
        wr(3'd0, 32'd1);
        chk_reg("R11 hard lock sec", 3'd0, 32'd7);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule